// File: doc/BRIEF.md
# D-PHY Data-Lane Low-Power State Monitor

This block observes the two single-ended low-power levels of one D-PHY data lane. Both levels arrive already sampled into the byte-clock domain. It follows the lane from the idle stop level through the high-speed request and the bridge level into high-speed reception, and then back to idle. When the bridge level is reached it turns on the differential termination. After a programmable settle time it marks the lane as receiving high speed, so that the sync search downstream may begin.

Any entry step taken out of order is reported through a sticky control-error flag, and the monitor then waits for a fresh stop level. After reset the monitor does not trust the lane until it has seen the stop level, so a lane that wakes up in the middle of a burst is never treated as valid. The end of a burst is signalled by the high-speed path. The monitor then drops termination and expects the lane to pass back through the bridge level to the stop level.

Top module: `lp_lane_mon`

## Requirements
- R1: While `rst` is high at a clock edge, the monitor goes to state 0 (wait-for-stop) and `hs_active`, `term_en` and `ctrl_err` are low.
- R2: In wait-for-stop, the line pair {dp,dn}=11 moves the state to 1 (stop) at the next edge. The codes 00, 01 and 10 keep it in state 0 and raise no error.
- R3: In stop, {dp,dn}=01 (request) moves the state to 2 (request). In request, 01 holds the state and 00 (bridge) moves it to 3 (settle), with `term_en` high from that same edge.
- R4: With `settle_cnt`=N, held stable, `hs_active` rises and the state becomes 4 (high speed) exactly N+1 edges after the edge that entered settle. During settle the line levels and `hs_done` have no effect, and during high speed the line levels have no effect.
- R5: In high speed, `hs_done` high at an edge moves the state to 5 (exit) and clears `hs_active` and `term_en` at that edge.
- R6: In exit, {dp,dn}=00 holds the state and 11 returns it to 1 (stop).
- R7: The following line codes are entry violations: 10 or 00 in stop, 11 or 10 in request, and 01 or 10 in exit. Each one sets `ctrl_err` and moves the state to 0 at the same edge.
- R8: `ctrl_err` stays high until `err_clr` is high at an edge. A new violation at that edge keeps it high.
- R9: `term_en` is high exactly in states 3 and 4, and `hs_active` is high exactly in state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_dp | input | 1 | Sampled low-power level of the positive line |
| lp_dn | input | 1 | Sampled low-power level of the negative line |
| hs_done | input | 1 | End-of-burst pulse from the high-speed path |
| settle_cnt | input | SETTLE_W | Settle wait in clock cycles, minus one |
| err_clr | input | 1 | Clears the sticky control error |
| state | output | 3 | Current monitor state (0..5) |
| hs_active | output | 1 | Lane is in high-speed reception |
| term_en | output | 1 | Differential termination enable |
| ctrl_err | output | 1 | Sticky lane control error |

## Verification
A wrong internal state shows up on the `state` port at the edge after the stimulus, since every output is a register fed from the same next-value struct. A miscounted settle wait moves the rise of `hs_active` by one or more edges. The bench therefore checks every step of the settle window across a sweep of settle values. A missed or spurious violation shows within one edge as a wrong `ctrl_err` together with a wrong return to state 0. Leaked stickiness shows on the cycle after the flag should have held or cleared.

// File: rtl/lpmon_pkg.sv
package lpmon_pkg;

    typedef enum logic [2:0] {
        LM_WAIT   = 3'd0,
        LM_STOP   = 3'd1,
        LM_REQ    = 3'd2,
        LM_SETTLE = 3'd3,
        LM_HS     = 3'd4,
        LM_EXIT   = 3'd5
    } lm_state_e;

    typedef struct packed {
        logic lvl_stop;    // 11
        logic lvl_req;     // 01
        logic lvl_bridge;  // 00
        logic lvl_odd;     // 10
    } lm_level_t;

    typedef struct packed {
        lm_state_e st;
        logic      hs;
        logic      term;
        logic      err;
    } lm_regs_t;

endpackage

// File: rtl/lp_line_decode.sv
module lp_line_decode
    import lpmon_pkg::*;
(
    input  logic      dp,
    input  logic      dn,
    output lm_level_t lvl
);
    always_comb begin
        lvl            = '0;
        lvl.lvl_stop   = dp  & dn;
        lvl.lvl_req    = ~dp & dn;
        lvl.lvl_bridge = ~dp & ~dn;
        lvl.lvl_odd    = dp  & ~dn;
    end
endmodule

// File: rtl/lp_settle_timer.sv
module lp_settle_timer #(
    parameter int SETTLE_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic [SETTLE_W-1:0] limit,
    output logic                done
);
    logic [SETTLE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == limit);

    // R4: every settle window starts counting from zero
    a_r4_cnt_zero_on_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> cnt_q == '0);
endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
    import lpmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lm_level_t lvl,
    input  logic      hs_done,
    input  logic      err_clr,
    input  logic      tmr_done,
    output logic      tmr_run,
    output lm_state_e st,
    output logic      hs,
    output logic      term,
    output logic      err
);
    lm_regs_t r_d, r_q;
    logic     viol;

    always_comb begin
        r_d  = r_q;
        viol = 1'b0;
        unique case (r_q.st)
            LM_WAIT: begin
                if (lvl.lvl_stop) r_d.st = LM_STOP;
            end
            LM_STOP: begin
                if (lvl.lvl_req)                        r_d.st = LM_REQ;
                else if (lvl.lvl_odd || lvl.lvl_bridge) viol   = 1'b1;
            end
            LM_REQ: begin
                if (lvl.lvl_bridge)                   r_d.st = LM_SETTLE;
                else if (lvl.lvl_stop || lvl.lvl_odd) viol   = 1'b1;
            end
            LM_SETTLE: begin
                if (tmr_done) r_d.st = LM_HS;
            end
            LM_HS: begin
                if (hs_done) r_d.st = LM_EXIT;
            end
            LM_EXIT: begin
                if (lvl.lvl_stop)                    r_d.st = LM_STOP;
                else if (lvl.lvl_req || lvl.lvl_odd) viol   = 1'b1;
            end
            default: r_d.st = LM_WAIT;
        endcase
        if (viol) r_d.st = LM_WAIT;
        r_d.err  = (r_q.err & ~err_clr) | viol;
        r_d.hs   = (r_d.st == LM_HS);
        r_d.term = (r_d.st == LM_SETTLE) || (r_d.st == LM_HS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= LM_WAIT;
            r_q.hs   <= 1'b0;
            r_q.term <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tmr_run = (r_q.st == LM_SETTLE);
    assign st      = r_q.st;
    assign hs      = r_q.hs;
    assign term    = r_q.term;
    assign err     = r_q.err;

    // R2: wait-for-stop only ever exits to stop
    a_r2_wait_exit: assert property (@(posedge clk) disable iff (rst)
        r_q.st == LM_WAIT |=> (r_q.st == LM_WAIT) || (r_q.st == LM_STOP));
    // R3: a request is only entered from stop
    a_r3_req_after_stop: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == LM_REQ) && ($past(r_q.st) != LM_REQ) |-> $past(r_q.st) == LM_STOP);
    // R4: settle is left only when the timer says so
    a_r4_settle_hold: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == LM_SETTLE) && !tmr_done |=> r_q.st == LM_SETTLE);
    // R4: high speed begins only out of settle
    a_r4_hs_from_settle: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.hs) |-> $past(r_q.st) == LM_SETTLE);
    // R7: a fresh error lands in wait-for-stop
    a_r7_err_to_wait: assert property (@(posedge clk) disable iff (rst)
        r_q.err && !$past(r_q.err) |-> r_q.st == LM_WAIT);
    // R8: the error flag stays until cleared
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        r_q.err && !err_clr |=> r_q.err);
    // R9: high speed never runs without termination
    a_r9_hs_needs_term: assert property (@(posedge clk) disable iff (rst)
        r_q.hs |-> r_q.term);
endmodule

// File: rtl/lp_lane_mon.sv
module lp_lane_mon
    import lpmon_pkg::*;
#(
    parameter int SETTLE_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lp_dp,
    input  logic                lp_dn,
    input  logic                hs_done,
    input  logic [SETTLE_W-1:0] settle_cnt,
    input  logic                err_clr,
    output logic [2:0]          state,
    output logic                hs_active,
    output logic                term_en,
    output logic                ctrl_err
);
    lm_level_t lvl;
    lm_state_e st;
    logic      tmr_run, tmr_done;

    lp_line_decode u_dec (
        .dp  (lp_dp),
        .dn  (lp_dn),
        .lvl (lvl)
    );

    lp_settle_timer #(.SETTLE_W(SETTLE_W)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .run   (tmr_run),
        .limit (settle_cnt),
        .done  (tmr_done)
    );

    lp_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .hs_done  (hs_done),
        .err_clr  (err_clr),
        .tmr_done (tmr_done),
        .tmr_run  (tmr_run),
        .st       (st),
        .hs       (hs_active),
        .term     (term_en),
        .err      (ctrl_err)
    );

    assign state = st;
endmodule

// File: tb/lp_lane_mon_bench.sv
module lp_lane_mon_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 6;
    localparam int S_WAIT = 0, S_STOP = 1, S_REQ = 2, S_SET = 3, S_HS = 4, S_EXIT = 5;

    logic          clk = 0, rst = 1, dp = 1, dn = 1, hs_done = 0, err_clr = 0;
    logic [SW-1:0] settle = '0;
    logic [2:0]    state;
    logic          hs_active, term_en, ctrl_err;
    int            n_cmp = 0, n_bad = 0;

    lp_lane_mon #(.SETTLE_W(SW)) u_lp_lane_mon (
        .clk(clk), .rst(rst), .lp_dp(dp), .lp_dn(dn), .hs_done(hs_done),
        .settle_cnt(settle), .err_clr(err_clr), .state(state),
        .hs_active(hs_active), .term_en(term_en), .ctrl_err(ctrl_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cmp(input string req, input string what, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    // expected outputs derive from the state per R9
    task automatic expect_all(input string req, input int st, input int er);
        cmp(req, "state", int'(state), st);
        cmp(req, "hs_active", int'(hs_active), (st == S_HS) ? 1 : 0);
        cmp(req, "term_en", int'(term_en), (st == S_SET || st == S_HS) ? 1 : 0);
        cmp(req, "ctrl_err", int'(ctrl_err), er);
    endtask

    task automatic step(input logic [1:0] lv, input logic done_i = 1'b0, input logic clr = 1'b0);
        {dp, dn} = lv;
        hs_done  = done_i;
        err_clr  = clr;
        @(negedge clk);
        hs_done  = 1'b0;
        err_clr  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        expect_all("R1", S_WAIT, 0);
        rst = 0;

        // R2: levels other than 11 hold wait-for-stop (mid-burst power-up)
        step(2'b00); expect_all("R2", S_WAIT, 0);
        step(2'b01); expect_all("R2", S_WAIT, 0);
        step(2'b10); expect_all("R2", S_WAIT, 0);
        step(2'b11); expect_all("R2", S_STOP, 0);

        // R3..R6: full bursts across a sweep of settle values
        for (int n = 0; n < 10; n++) begin
            int nv;
            nv = (n == 9) ? 20 : n;
            settle = SW'(nv);
            step(2'b11); expect_all("R6", S_STOP, 0);
            step(2'b01); expect_all("R3", S_REQ, 0);
            step(2'b01); expect_all("R3", S_REQ, 0);
            step(2'b00); expect_all("R3", S_SET, 0);
            for (int j = 1; j <= nv + 1; j++) begin
                // R4: lines and hs_done disturbed during settle have no effect
                step((j % 2) ? 2'b11 : 2'b10, 1'b1);
                expect_all("R4", (j == nv + 1) ? S_HS : S_SET, 0);
            end
            step(2'b01); expect_all("R4", S_HS, 0);
            step(2'b11); expect_all("R4", S_HS, 0);
            step(2'b00, 1'b1); expect_all("R5", S_EXIT, 0);
            step(2'b00); expect_all("R6", S_EXIT, 0);
            step(2'b11); expect_all("R6", S_STOP, 0);
        end

        // R7/R8: violations in stop
        for (int k = 0; k < 2; k++) begin
            step(2'b11); expect_all("R7", S_STOP, 0);
            step(k ? 2'b00 : 2'b10); expect_all("R7", S_WAIT, 1);
            step(2'b01); expect_all("R8", S_WAIT, 1);
            step(2'b11); expect_all("R8", S_STOP, 1);
            step(2'b11, 1'b0, 1'b1); expect_all("R8", S_STOP, 0);
        end
        // R7: violations in request
        for (int k = 0; k < 2; k++) begin
            step(2'b01); expect_all("R3", S_REQ, 0);
            step(k ? 2'b10 : 2'b11); expect_all("R7", S_WAIT, 1);
            step(2'b11, 1'b0, 1'b1); expect_all("R8", S_STOP, 0);
        end
        // R7: violations in exit
        settle = '0;
        for (int k = 0; k < 2; k++) begin
            step(2'b01); step(2'b00); step(2'b00);
            expect_all("R4", S_HS, 0);
            step(2'b00, 1'b1); expect_all("R5", S_EXIT, 0);
            step(k ? 2'b10 : 2'b01); expect_all("R7", S_WAIT, 1);
            step(2'b11, 1'b0, 1'b1); expect_all("R8", S_STOP, 0);
        end
        // R8: a violation wins over a clear at the same edge
        step(2'b11); expect_all("R7", S_STOP, 0);
        step(2'b10); expect_all("R7", S_WAIT, 1);
        step(2'b11); expect_all("R8", S_STOP, 1);
        step(2'b00, 1'b0, 1'b1); expect_all("R8", S_WAIT, 1);
        step(2'b11, 1'b0, 1'b1); expect_all("R8", S_STOP, 0);

        // R1: reset from the middle of a burst
        step(2'b01); step(2'b00); expect_all("R3", S_SET, 0);
        rst = 1; step(2'b00); expect_all("R1", S_WAIT, 0);
        rst = 0; step(2'b00); expect_all("R2", S_WAIT, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule